// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block runs single-word operations on a three-wire serial EEPROM: a select line, a serial clock, a serial data line to the device and a data line back from it. The host gives a one-cycle command strobe with an operation code, a word address and a 16-bit write value. The block keeps `busy` high while the access runs. It pulses `done` when the access is over. A read leaves the fetched word on `rdata`. A probe operation works out at run time whether the attached part decodes 6 or 8 address bits, and every later access uses that width.

A programmable divider makes the serial clock. Each half-period lasts `HALF_CYC` system clocks. A write does not end when its last data bit goes out. The block deselects the device for one half-period, selects it again, and samples the device's data-out line once per half-period until the part reports ready. If the part never reports ready, the block gives up after `POLL_LIMIT` samples, sets a timeout flag and still completes the access.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done`, `ee_cs`, `ee_sk`, `ee_di`, `timeout` and `addr_wide` are 0, and `rdata` is 0.
- R2: A probe (code 5) sends 29 clocks in one select period. The bits sent are two 0 bits, then 1,1,0, then eight 1 bits; the data line to the device is 0 for the rest. The 29 samples form a word with the first sample at bit 28. `addr_wide` becomes that word's bit 18 (1 = 8 address bits, 0 = 6).
- R3: Select rises one half-period before the first bit is driven. The data line to the device changes only while the serial clock is low. The serial clock is high only while select is high. Select falls only while the clock is low. Select stays low for at least one half-period between accesses. Every field is sent MSB first.
- R4: A read (code 0) sends 1,1,0, then the address at the current width, then 16 more clocks. `rdata` is the last 16 samples, first sample in bit 15. Address bits above the current width are ignored.
- R5: Write-enable (code 1) sends 1,0,0 and then an address field whose top two bits are 11 and whose other bits are 0. Write-disable (code 3) sends the same frame with those two bits at 00.
- R6: A write (code 2) sends 1,0,1, the address and the 16 data bits in one select period. Select then stays low for one half-period and rises again. The data-out line is sampled once per half-period until it is high. `done` follows, with `timeout` at 0.
- R7: An erase (code 4) sends 1,1,1 and the address only: 3 plus the address width clocks. No ready poll follows.
- R8: If `POLL_LIMIT` ready samples in a row all read low, select drops, `timeout` becomes 1 and `done` still pulses. The next accepted command clears `timeout`.
- R9: A command is accepted only while `busy` is low and only for codes 0 to 5. `busy` rises on the cycle after acceptance. `done` is a one-cycle pulse in the cycle where `busy` falls.
- R10: `rdata` changes only when a read completes, and `addr_wide` only when a probe completes, both in the cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 read, 1 write-enable, 2 write, 3 write-disable, 4 erase, 5 probe |
| cmd_addr | input | WIDE_AW | Word address |
| cmd_wdata | input | DATA_W | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last word read |
| addr_wide | output | 1 | 1 when the device uses the wide address |
| timeout | output | 1 | Last write gave up waiting for ready |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The bench attaches a behavioural EEPROM whose address width can be switched between 6 and 8. It probes both widths; a design that sampled the wrong bit of the capture would report the same width for both parts. A narrow read with high address bits set must return the masked word, and a design that did not mask would return a different word. Writes are tried with the device write-enabled and write-disabled; a design that sent a wrong enable field would leave the word unchanged. After each write the bench checks that the model's busy time has passed, which catches a design that skips the ready poll. A stuck-busy device must give `timeout` with `done`, and a strobe sent mid-access must not start a second frame.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [2:0] {
      CMD_READ  = 3'd0,
      CMD_WREN  = 3'd1,
      CMD_WRITE = 3'd2,
      CMD_WRDIS = 3'd3,
      CMD_ERASE = 3'd4,
      CMD_PROBE = 3'd5
   } uw_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE, S_CSUP, S_LO, S_HI, S_END, S_PGAP, S_POLL, S_GAP
   } uw_state_e;

   // start bit included as the leading 1
   localparam logic [2:0] OPC_READ  = 3'b110;
   localparam logic [2:0] OPC_WRITE = 3'b101;
   localparam logic [2:0] OPC_ERASE = 3'b111;
   localparam logic [2:0] OPC_MODE  = 3'b100;

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
   localparam bit POW2 = ((HALF_CYC & (HALF_CYC - 1)) == 0);

   logic [CW-1:0] cnt;

   if (HALF_CYC < 2) begin : g_bad_half
      $error("uwire_tick: HALF_CYC must be at least 2");
   end

   if (POW2) begin : g_wrap
      // natural wrap of the counter, no terminal compare in the next-state path
      always_ff @(posedge clk) begin
         if (!rst_n || restart) cnt <= '0;
         else                   cnt <= cnt + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n || restart || cnt == LAST) cnt <= '0;
         else                                  cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == LAST) && !restart;
endmodule

// File: rtl/uwire_pollcnt.sv
module uwire_pollcnt #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam int PW = $clog2(LIMIT + 1);
   localparam logic [PW-1:0] LAST_V = PW'(LIMIT - 1);

   logic [PW-1:0] cnt;

   if (LIMIT < 1) begin : g_bad_limit
      $error("uwire_pollcnt: LIMIT must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (step)       cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LAST_V);
endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
   import uwire_pkg::*;
#(
   parameter int WIDE_AW   = 8,
   parameter int NARROW_AW = 6,
   parameter int DATA_W    = 16,
   parameter int FW        = 5 + WIDE_AW + DATA_W,
   parameter int LW        = $clog2(FW + 1)
) (
   input  logic [2:0]         cmd,
   input  logic [WIDE_AW-1:0] addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               wide,
   output logic [FW-1:0]      vec,
   output logic [LW-1:0]      len,
   output logic               legal
);
   localparam logic [LW-1:0]      L_TOP = LW'(FW - 3);
   localparam logic [LW-1:0]      L_DAT = LW'(DATA_W);
   localparam logic [WIDE_AW-1:0] NMASK = {{(WIDE_AW-NARROW_AW){1'b0}}, {NARROW_AW{1'b1}}};
   localparam logic [FW-1:0]      PROBE_VEC = {2'b00, OPC_READ, {WIDE_AW{1'b1}}, {DATA_W{1'b0}}};

   logic [LW-1:0] aw, sh_a, sh_d;
   logic [FW-1:0] a_fld, d_fld;
   logic [2:0]    opc;
   logic          with_data;

   always_comb begin
      aw        = wide ? LW'(WIDE_AW) : LW'(NARROW_AW);
      sh_a      = L_TOP - aw;
      sh_d      = sh_a - L_DAT;
      a_fld     = FW'(wide ? addr : (addr & NMASK));
      d_fld     = FW'(wdata);
      opc       = OPC_READ;
      with_data = 1'b0;
      legal     = 1'b1;
      case (cmd)
         CMD_READ:  begin opc = OPC_READ;  with_data = 1'b1; d_fld = '0; end
         CMD_WREN:  begin opc = OPC_MODE;  a_fld = FW'(2'b11) << (aw - LW'(2)); end
         CMD_WRDIS: begin opc = OPC_MODE;  a_fld = '0; end
         CMD_WRITE: begin opc = OPC_WRITE; with_data = 1'b1; end
         CMD_ERASE: opc = OPC_ERASE;
         CMD_PROBE: opc = OPC_READ;
         default:   legal = 1'b0;
      endcase
      if (!with_data) d_fld = '0;
      vec = (FW'(opc) << L_TOP) | (a_fld << sh_a) | (d_fld << sh_d);
      len = LW'(3) + aw + (with_data ? L_DAT : '0);
      if (cmd == CMD_PROBE) begin
         vec = PROBE_VEC;
         len = LW'(FW);
      end
   end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
   import uwire_pkg::*;
#(
   parameter int HALF_CYC   = 4,
   parameter int POLL_LIMIT = 10000,
   parameter int WIDE_AW    = 8,
   parameter int NARROW_AW  = 6,
   parameter int DATA_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [WIDE_AW-1:0] cmd_addr,
   input  logic [DATA_W-1:0]  cmd_wdata,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rdata,
   output logic               addr_wide,
   output logic               timeout,
   output logic               ee_cs,
   output logic               ee_sk,
   output logic               ee_di,
   input  logic               ee_do
);
   localparam int FW      = 5 + WIDE_AW + DATA_W;
   localparam int LW      = $clog2(FW + 1);
   localparam int DET_BIT = FW - 1 - (4 + NARROW_AW);

   if (NARROW_AW < 2 || NARROW_AW >= WIDE_AW) begin : g_bad_aw
      $error("uwire_eeprom_ctrl: need 2 <= NARROW_AW < WIDE_AW");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("uwire_eeprom_ctrl: DATA_W must be positive");
   end

   uw_state_e     st;
   uw_cmd_e       cur;
   logic [FW-1:0] tx_sr, rx_sr, f_vec;
   logic [LW-1:0] bits_left, f_len;
   logic          f_legal, accept, tick, p_last;

   assign accept = cmd_valid && (st == S_IDLE) && f_legal;
   assign busy   = (st != S_IDLE);

   uwire_frame #(.WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW), .DATA_W(DATA_W),
                 .FW(FW), .LW(LW)) u_frame (
      .cmd(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata), .wide(addr_wide),
      .vec(f_vec), .len(f_len), .legal(f_legal));

   uwire_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick));

   uwire_pollcnt #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk(clk), .rst_n(rst_n), .clear(st == S_PGAP),
      .step(st == S_POLL && tick), .last(p_last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cur       <= CMD_READ;
         tx_sr     <= '0;
         rx_sr     <= '0;
         bits_left <= '0;
         done      <= 1'b0;
         rdata     <= '0;
         addr_wide <= 1'b0;
         timeout   <= 1'b0;
         ee_cs     <= 1'b0;
         ee_sk     <= 1'b0;
         ee_di     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_IDLE: if (accept) begin
               st        <= S_CSUP;
               cur       <= uw_cmd_e'(cmd_op);
               tx_sr     <= f_vec;
               bits_left <= f_len;
               rx_sr     <= '0;
               timeout   <= 1'b0;
               ee_cs     <= 1'b1;
            end
            S_CSUP: if (tick) begin
               ee_di <= tx_sr[FW-1];
               tx_sr <= tx_sr << 1;
               st    <= S_LO;
            end
            S_LO: if (tick) begin
               ee_sk <= 1'b1;
               st    <= S_HI;
            end
            S_HI: if (tick) begin
               ee_sk     <= 1'b0;
               rx_sr     <= {rx_sr[FW-2:0], ee_do};
               bits_left <= bits_left - 1'b1;
               if (bits_left == LW'(1)) begin
                  ee_di <= 1'b0;
                  st    <= S_END;
               end else begin
                  ee_di <= tx_sr[FW-1];
                  tx_sr <= tx_sr << 1;
                  st    <= S_LO;
               end
            end
            S_END: if (tick) begin
               ee_cs <= 1'b0;
               st    <= (cur == CMD_WRITE) ? S_PGAP : S_GAP;
            end
            S_PGAP: if (tick) begin
               ee_cs <= 1'b1;
               st    <= S_POLL;
            end
            S_POLL: if (tick && (ee_do || p_last)) begin
               ee_cs   <= 1'b0;
               timeout <= !ee_do;
               st      <= S_GAP;
            end
            S_GAP: if (tick) begin
               done <= 1'b1;
               st   <= S_IDLE;
               if (cur == CMD_READ)  rdata     <= rx_sr[DATA_W-1:0];
               if (cur == CMD_PROBE) addr_wide <= rx_sr[DET_BIT];
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uwire_chk.sv
module uwire_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rdata,
   input logic              addr_wide,
   input logic              ee_cs,
   input logic              ee_sk,
   input logic              ee_di
);
   // R3
   sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);
   // R3
   cs_drop_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> (!ee_sk && !$past(ee_sk)));
   // R3
   di_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> $stable(ee_di));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R9
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op <= 3'd5) |=> busy);
   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rdata));
   // R10
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(addr_wide));
endmodule

bind uwire_eeprom_ctrl uwire_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .busy(busy), .done(done), .rdata(rdata), .addr_wide(addr_wide),
   .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di));

// File: tb/test_uwire_eeprom_ctrl.sv
module test_uwire_eeprom_ctrl;
   import uwire_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;
   localparam int POLL       = 20;
   localparam int WBUSY      = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [7:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        busy, done, addr_wide, timeout, ee_cs, ee_sk, ee_di, ee_do;
   logic [15:0] rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   uwire_eeprom_ctrl #(.HALF_CYC(HALF), .POLL_LIMIT(POLL)) i_uwire_eeprom_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
      .rdata(rdata), .addr_wide(addr_wide), .timeout(timeout),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural EEPROM ----------------
   logic [15:0] mem [0:255];
   int   m_aw = 8;
   bit   m_wen = 0, stuck = 0, started = 0, reading = 0, writing = 0;
   bit   wr_pend = 0, polling = 0;
   int   n = 0, frames = 0, cur_bits = 0, last_bits = 0;
   int   cyc = 0, busy_end = 0;
   logic [31:0] sh = '0;
   logic [15:0] rd_word = '0;
   logic [7:0]  wa = '0;
   logic        m_do = 1'b1;

   always @(negedge clk) cyc++;

   assign ee_do = (ee_cs && polling && !started) ? (!stuck && cyc >= busy_end) : m_do;

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         if (cur_bits > 0) last_bits = cur_bits;
         if (started) frames++;
         cur_bits = 0; started = 0; reading = 0; writing = 0; m_do = 1'b1;
         if (wr_pend) begin busy_end = cyc + WBUSY; polling = 1; wr_pend = 0; end
      end else begin
         cur_bits++;
         if (!started) begin
            if (ee_di) begin started = 1; n = 0; polling = 0; end
         end else begin
            n++;
            sh = {sh[30:0], ee_di};
            if (n == 2 + m_aw) begin
               logic [7:0] ad;
               ad = 8'(sh & ((32'd1 << m_aw) - 1));
               case (sh[m_aw+1 -: 2])
                  2'b10: begin rd_word = mem[ad]; reading = 1; m_do = 1'b0; end
                  2'b11: if (m_wen) mem[ad] = 16'hFFFF;
                  2'b01: begin writing = 1; wa = ad; end
                  default: begin
                     if ((ad >> (m_aw - 2)) == 8'd3) m_wen = 1;
                     if ((ad >> (m_aw - 2)) == 8'd0) m_wen = 0;
                  end
               endcase
            end else if (reading && n > 2 + m_aw) begin
               m_do = (n - 2 - m_aw <= 16) ? rd_word[18 + m_aw - n] : 1'b1;
            end else if (writing && n == 2 + m_aw + 16) begin
               if (m_wen) mem[wa] = sh[15:0];
               wr_pend = 1;
            end
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [15:0] rd;
      logic        wide;
      logic        to;
      string       tag;
   } exp_t;
   exp_t q[$];
   logic [15:0] exp_rd = '0;
   logic        exp_wide = 1'b0;

   always @(negedge clk) begin
      if (done) begin
         if (q.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(rdata == e.rd, e.tag, "rdata", 32'(rdata), 32'(e.rd));
            check(addr_wide == e.wide, e.tag, "addr_wide", 32'(addr_wide), 32'(e.wide));
            check(timeout == e.to, e.tag, "timeout", 32'(timeout), 32'(e.to));
         end
      end
   end

   // R3: select low for at least one half-period between accesses
   int lowcnt = 0;
   logic cs_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && ee_cs && !cs_prev)
         check(lowcnt >= HALF, "R3", "select low gap", 32'(lowcnt), 32'(HALF));
      lowcnt  = ee_cs ? 0 : lowcnt + 1;
      cs_prev = ee_cs;
   end

   task automatic run_cmd(input uw_cmd_e op, input logic [7:0] a, input logic [15:0] d,
                          input bit to, input string tag);
      exp_t e;
      if (op == CMD_READ) exp_rd = mem[m_aw == 8 ? a : (a & 8'h3F)];
      if (op == CMD_PROBE) exp_wide = (m_aw == 8);
      e.rd = exp_rd; e.wide = exp_wide; e.to = to; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !timeout && !addr_wide, "R1", "flags in reset", {busy, done, timeout, addr_wide}, 0);
      check(!ee_cs && !ee_sk && !ee_di, "R1", "serial lines in reset", {ee_cs, ee_sk, ee_di}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdata == 16'h0 && !busy, "R1", "after release", 32'(rdata), 0);

      // R2 probe, narrow part
      m_aw = 6;
      run_cmd(CMD_PROBE, 8'h00, 16'h0, 1'b0, "R2");
      // R4 narrow reads, high address bits masked
      run_cmd(CMD_READ, 8'h2A, 16'h0, 1'b0, "R4");
      run_cmd(CMD_READ, 8'hC5, 16'h0, 1'b0, "R4");
      // R7 narrow erase length (not enabled, so no change)
      run_cmd(CMD_ERASE, 8'h07, 16'h0, 1'b0, "R7");
      check(last_bits == 9, "R7", "narrow erase clocks", 32'(last_bits), 32'd9);

      // R2 probe, wide part
      m_aw = 8;
      run_cmd(CMD_PROBE, 8'h00, 16'h0, 1'b0, "R2");
      check(last_bits == 29, "R2", "probe clocks", 32'(last_bits), 32'd29);
      run_cmd(CMD_READ, 8'hC5, 16'h0, 1'b0, "R4");
      check(last_bits == 27, "R4", "wide read clocks", 32'(last_bits), 32'd27);

      // R5 write without enable leaves the word; R10 rdata unchanged by write
      run_cmd(CMD_WRITE, 8'h33, 16'hBEEF, 1'b0, "R10");
      run_cmd(CMD_READ, 8'h33, 16'h0, 1'b0, "R5");
      // R5 enable, R6 write with poll
      run_cmd(CMD_WREN, 8'h00, 16'h0, 1'b0, "R5");
      check(m_wen == 1'b1, "R5", "enable frame", 32'(m_wen), 32'd1);
      run_cmd(CMD_WRITE, 8'h33, 16'hBEEF, 1'b0, "R6");
      check(cyc >= busy_end, "R6", "done before device ready", 32'(cyc), 32'(busy_end));
      check(last_bits == 27, "R6", "write clocks", 32'(last_bits), 32'd27);
      run_cmd(CMD_READ, 8'h33, 16'h0, 1'b0, "R6");
      // R7 erase
      run_cmd(CMD_ERASE, 8'h40, 16'h0, 1'b0, "R7");
      check(last_bits == 11, "R7", "erase clocks", 32'(last_bits), 32'd11);
      run_cmd(CMD_READ, 8'h40, 16'h0, 1'b0, "R7");
      // R5 disable blocks a write
      run_cmd(CMD_WRDIS, 8'h00, 16'h0, 1'b0, "R5");
      check(m_wen == 1'b0, "R5", "disable frame", 32'(m_wen), 32'd0);
      run_cmd(CMD_WRITE, 8'h40, 16'h1234, 1'b0, "R5");
      run_cmd(CMD_READ, 8'h40, 16'h0, 1'b0, "R5");

      // R8 poll timeout, then cleared by the next command
      run_cmd(CMD_WREN, 8'h00, 16'h0, 1'b0, "R5");
      stuck = 1;
      run_cmd(CMD_WRITE, 8'h10, 16'hA55A, 1'b1, "R8");
      stuck = 0;
      run_cmd(CMD_READ, 8'h10, 16'h0, 1'b0, "R8");

      // R9 strobe during an access is ignored
      begin
         int f0;
         logic [15:0] m0;
         exp_t e;
         f0 = frames; m0 = mem[8'h11];
         exp_rd = m0; e.rd = m0; e.wide = exp_wide; e.to = 1'b0; e.tag = "R9";
         q.push_back(e);
         @(negedge clk);
         cmd_valid = 1'b1; cmd_op = CMD_READ; cmd_addr = 8'h11;
         @(negedge clk);
         cmd_valid = 1'b0;
         repeat (20) @(negedge clk);
         cmd_valid = 1'b1; cmd_op = CMD_WRITE; cmd_addr = 8'h11; cmd_wdata = 16'h0;
         @(negedge clk);
         cmd_valid = 1'b0;
         while (busy) @(negedge clk);
         repeat (HALF * 4) @(negedge clk);
         check(frames == f0 + 1, "R9", "frames during busy strobe", 32'(frames), 32'(f0 + 1));
         check(mem[8'h11] == m0, "R9", "word after busy strobe", 32'(mem[8'h11]), 32'(m0));
      end
      // R9 illegal code not accepted
      begin
         int f1;
         f1 = frames;
         cmd_valid = 1'b1; cmd_op = 3'd7;
         @(negedge clk);
         cmd_valid = 1'b0;
         @(negedge clk);
         check(!busy, "R9", "busy after code 7", 32'(busy), 32'd0);
         repeat (HALF * 4) @(negedge clk);
         check(frames == f1 && !ee_cs, "R9", "frames after code 7", 32'(frames), 32'(f1));
      end
      check(q.size() == 0, "R9", "outstanding results", 32'(q.size()), 32'd0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule